// File: doc/BRIEF.md
# Serial Transmitter with Line Control

This block is the sending half of an asynchronous serial port. Software writes bytes into a sixteen-entry queue through a small write-only register bus. A serializer then takes each byte and shifts it out on a single output line. Around the data bits it adds a start bit, an optional parity bit and one or two stop bits. A line-control register sets the character length, the parity and the stop bits, gates the start of new characters, and can force a break condition onto the line.

The bit rate comes from a 10-bit divisor. It is measured against a fixed reference tick that runs at 921600 per second, so the bit rate is 921600/(divisor+1). The parameter `PRESCALE` gives the number of system clocks per reference tick. One bit therefore lasts `PRESCALE*(divisor+1)` clocks. A write to the divisor does not take effect at once. A flag stays high until the new value is in use, and software waits for that flag to clear before it writes again. The queue fill level is always visible, and a busy output shows when the line has fully drained.

Bus addresses: 0 is the divisor (low 10 bits), 1 is line control, 2 pushes `wr_data[7:0]` into the queue, and 3 is ignored.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd` is 1, `fifo_index` is 0, `tx_busy` and `div_busy` are 0, line control is all zero (transmit disabled), and the divisor is 7, so one bit lasts `8*PRESCALE` clocks.
- R2: A character is sent as a low start bit, then the data bits least significant first, then the stop bits. Every bit lasts `PRESCALE*(divisor+1)` clocks, and the line changes only at bit boundaries.
- R3: Line-control bit 2 selects 8 data bits when 1 and 7 data bits when 0. With 7 bits, data bit 7 is not sent.
- R4: Line-control bit 4 adds a parity bit after the data. Line-control bit 5 selects odd parity when 1 and even parity when 0. Parity covers only the bits that are sent.
- R5: Line-control bit 3 selects two stop bits when 1 and one stop bit when 0. Stop bits are high.
- R6: A write to address 2 enqueues `wr_data[7:0]`. `fifo_index` shows the fill count (0 to 16), and bit 4 of it is set only when the queue is full. A push while full is dropped. Bytes leave in the order they were written.
- R7: Line-control bit 0 enables transmission. While it is 0, no new character starts, and queued bytes stay in the queue.
- R8: A divisor write raises `div_busy` on the next cycle. `div_busy` falls within one bit period of the old divisor. From then on, bits use the new divisor.
- R9: Line-control bit 9 drives `txd` low once the current character is finished. When the bit is cleared, `txd` goes high at the next bit boundary and stays high for at least one full bit before the next start bit.
- R10: `tx_busy` is high while the queue holds data or a character is on the line. It falls only after the last stop bit has ended. When `tx_busy` is low and no break is active, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor, 1 line control, 2 queue push |
| wr_data | input | 10 | Write data |
| txd | output | 1 | Serial output line, idles high |
| fifo_index | output | 5 | Queue fill count, bit 4 set when full |
| div_busy | output | 1 | High while a divisor update is pending |
| tx_busy | output | 1 | High until the queue is empty and the last stop bit has ended |

## Verification
Frames are decoded on the line at the middle of each bit. A wrong bit period therefore drifts into the wrong bit within a few bits. A design that shifts the most significant bit first, counts parity over the unsent eighth bit, or drops the second stop bit fails the decode of the data, parity or stop bits.

The queue is filled to capacity while transmission is disabled, and then pushed once more. A design that overwrites an entry or wraps the count would send a seventeenth frame or show the wrong fill level. A design that ignores the enable would start sending early.

The bench times the divisor handover, the release of a break, and the fall of the busy flag against the bit period. This catches a divisor that switches in the middle of a bit, a break release that starts a frame with no idle bit first, and a busy flag that clears while the stop bit is still on the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // register addresses on the write bus
    localparam logic [1:0] ADDR_DIVISOR = 2'd0;
    localparam logic [1:0] ADDR_LINE    = 2'd1;
    localparam logic [1:0] ADDR_PUSH    = 2'd2;

    // line-control bit positions
    localparam int LB_TX_EN    = 0;
    localparam int LB_EIGHT    = 2;
    localparam int LB_TWO_STOP = 3;
    localparam int LB_PAR_EN   = 4;
    localparam int LB_ODD      = 5;
    localparam int LB_BREAK    = 9;

    typedef struct packed {
        logic brk;
        logic odd;
        logic par_en;
        logic two_stop;
        logic eight;
        logic tx_en;
    } line_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } tx_state_e;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t q, d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (q.count == CW'(DEPTH));
    assign empty = (q.count == '0);

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.wr_ptr = (q.wr_ptr == AW'(DEPTH-1)) ? '0 : q.wr_ptr + AW'(1);
        end
        if (do_pop) begin
            d.rd_ptr = (q.rd_ptr == AW'(DEPTH-1)) ? '0 : q.rd_ptr + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   d.count = q.count + CW'(1);
            2'b01:   d.count = q.count - CW'(1);
            default: d.count = q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[q.wr_ptr] <= push_data;
    end

    assign pop_data = mem_q[q.rd_ptr];
    assign count    = q.count;
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int PRESCALE  = 4,
    parameter int DIV_W     = 10,
    parameter int DIV_RESET = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             bit_tick,
    output logic             div_busy
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PW-1:0]    pre_cnt;
        logic [DIV_W-1:0] div_cnt;
        logic [DIV_W-1:0] active;
        logic [DIV_W-1:0] pending;
        logic             busy;
    } baud_state_t;

    baud_state_t q, d;
    logic ref_tick;

    always_comb begin
        d        = q;
        ref_tick = 1'b0;
        bit_tick = 1'b0;
        // reference tick at 921600 per second
        if (q.pre_cnt == PW'(PRESCALE-1)) begin
            d.pre_cnt = '0;
            ref_tick  = 1'b1;
        end else begin
            d.pre_cnt = q.pre_cnt + PW'(1);
        end
        // bit boundary after active+1 reference ticks
        if (ref_tick) begin
            if (q.div_cnt == q.active) begin
                d.div_cnt = '0;
                bit_tick  = 1'b1;
            end else begin
                d.div_cnt = q.div_cnt + DIV_W'(1);
            end
        end
        // divisor handover only on a bit boundary
        if (div_wr) begin
            d.pending = div_wdata;
            d.busy    = 1'b1;
        end else if (q.busy && bit_tick) begin
            d.active = q.pending;
            d.busy   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.active  <= DIV_W'(DIV_RESET);
            q.pending <= DIV_W'(DIV_RESET);
        end else begin
            q <= d;
        end
    end

    assign div_busy = q.busy;
endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  line_cfg_t         cfg,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              txd,
    output logic              frame_busy,
    output logic              in_break
);
    localparam int CW = $clog2(DATA_W+1);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shift;
        logic [CW-1:0]     bit_cnt;
        logic [CW-1:0]     nbits;
        logic              par_en;
        logic              par;
        logic              two_stop;
        logic              stop_left;
        logic              txd;
    } ser_state_t;

    ser_state_t q, d;
    logic launch;
    logic [DATA_W-1:0] mask, masked;

    always_comb begin
        mask   = cfg.eight ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
        masked = fifo_data & mask;
    end

    always_comb begin
        d        = q;
        launch   = 1'b0;
        fifo_pop = 1'b0;
        if (bit_tick) begin
            case (q.state)
                ST_IDLE: launch = 1'b1;
                ST_START: begin
                    d.txd     = q.shift[0];
                    d.shift   = q.shift >> 1;
                    d.bit_cnt = CW'(1);
                    d.state   = ST_DATA;
                end
                ST_DATA: begin
                    if (q.bit_cnt == q.nbits) begin
                        if (q.par_en) begin
                            d.txd   = q.par;
                            d.state = ST_PARITY;
                        end else begin
                            d.txd       = 1'b1;
                            d.state     = ST_STOP;
                            d.stop_left = q.two_stop;
                        end
                    end else begin
                        d.txd     = q.shift[0];
                        d.shift   = q.shift >> 1;
                        d.bit_cnt = q.bit_cnt + CW'(1);
                    end
                end
                ST_PARITY: begin
                    d.txd       = 1'b1;
                    d.state     = ST_STOP;
                    d.stop_left = q.two_stop;
                end
                ST_STOP: begin
                    if (q.stop_left) d.stop_left = 1'b0;
                    else             launch      = 1'b1;
                end
                ST_BREAK: begin
                    if (!cfg.brk) begin
                        d.txd   = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
                default: begin
                    d.txd   = 1'b1;
                    d.state = ST_IDLE;
                end
            endcase

            // choose what follows an idle bit or a finished frame
            if (launch) begin
                if (cfg.brk) begin
                    d.txd   = 1'b0;
                    d.state = ST_BREAK;
                end else if (cfg.tx_en && !fifo_empty) begin
                    fifo_pop   = 1'b1;
                    d.txd      = 1'b0;
                    d.state    = ST_START;
                    d.shift    = masked;
                    d.nbits    = cfg.eight ? CW'(DATA_W) : CW'(DATA_W-1);
                    d.par_en   = cfg.par_en;
                    d.par      = (^masked) ^ cfg.odd;
                    d.two_stop = cfg.two_stop;
                end else begin
                    d.txd   = 1'b1;
                    d.state = ST_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.txd   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd        = q.txd;
    assign frame_busy = (q.state != ST_IDLE) && (q.state != ST_BREAK);
    assign in_break   = (q.state == ST_BREAK);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int PRESCALE   = 4,
    parameter int DIV_W      = 10,
    parameter int DIV_RESET  = 7,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_addr,
    input  logic [((DIV_W > 10) ? DIV_W : 10)-1:0] wr_data,
    output logic                              txd,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_index,
    output logic                              div_busy,
    output logic                              tx_busy
);
    typedef struct packed {
        line_cfg_t lcr;
    } core_state_t;

    core_state_t q, d;

    logic              tx_push_req;
    logic              fifo_pop;
    logic              fifo_full;
    logic              fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic              bit_tick;
    logic              frame_busy;
    logic              in_break;
    logic              tx_enable;
    logic              div_wr;

    always_comb begin
        d = q;
        if (wr_en && (wr_addr == ADDR_LINE)) begin
            d.lcr.tx_en    = wr_data[LB_TX_EN];
            d.lcr.eight    = wr_data[LB_EIGHT];
            d.lcr.two_stop = wr_data[LB_TWO_STOP];
            d.lcr.par_en   = wr_data[LB_PAR_EN];
            d.lcr.odd      = wr_data[LB_ODD];
            d.lcr.brk      = wr_data[LB_BREAK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_push_req = wr_en && (wr_addr == ADDR_PUSH);
    assign div_wr      = wr_en && (wr_addr == ADDR_DIVISOR);
    assign tx_enable   = q.lcr.tx_en;

    uart_tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push_req),
        .push_data (wr_data[DATA_W-1:0]),
        .pop       (fifo_pop),
        .pop_data  (fifo_head),
        .count     (fifo_index),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    uart_tx_baud #(.PRESCALE(PRESCALE), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_wr    (div_wr),
        .div_wdata (wr_data[DIV_W-1:0]),
        .bit_tick  (bit_tick),
        .div_busy  (div_busy)
    );

    uart_tx_serial #(.DATA_W(DATA_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .cfg        (q.lcr),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_head),
        .fifo_pop   (fifo_pop),
        .txd        (txd),
        .frame_busy (frame_busy),
        .in_break   (in_break)
    );

    assign tx_busy = frame_busy || !fifo_empty;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk #(
    parameter int DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         txd,
    input logic                         tx_busy,
    input logic                         div_busy,
    input logic [$clog2(DEPTH+1)-1:0]   fifo_index,
    input logic                         wr_en,
    input logic [1:0]                   wr_addr,
    input logic                         bit_tick,
    input logic                         fifo_pop,
    input logic                         tx_push_req,
    input logic                         tx_enable,
    input logic                         in_break
);
    localparam int CW = $clog2(DEPTH+1);

    assert_bit_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_index == CW'(DEPTH) && tx_push_req && !fifo_pop) |=> (fifo_index == CW'(DEPTH)));

    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_index != '0));

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !fifo_pop);

    assert_div_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_busy) |-> $past(wr_en && wr_addr == 2'd0));

    assert_idle_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !in_break) |-> txd);
endmodule

bind uart_tx_core uart_tx_core_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd         (txd),
    .tx_busy     (tx_busy),
    .div_busy    (div_busy),
    .fifo_index  (fifo_index),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .bit_tick    (bit_tick),
    .fifo_pop    (fifo_pop),
    .tx_push_req (tx_push_req),
    .tx_enable   (tx_enable),
    .in_break    (in_break)
);

// File: tb/uart_tx_core_test.sv
module uart_tx_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int PRESCALE   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [9:0] wr_data = '0;
    logic       txd;
    logic [4:0] fifo_index;
    logic       div_busy;
    logic       tx_busy;

    uart_tx_core #(.PRESCALE(PRESCALE)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .txd(txd), .fifo_index(fifo_index),
        .div_busy(div_busy), .tx_busy(tx_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [7:0] data;
        int         nbits;
        bit         par_en;
        bit         odd;
        int         nstop;
    } frame_t;

    frame_t expq[$];
    int  checks = 0;
    int  errors = 0;
    int  bit_clks = 8 * PRESCALE;
    bit  mon_en = 1'b1;
    bit  c_eight = 1'b0, c_par = 1'b0, c_odd = 1'b0, c_two = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [9:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_line(input bit en, input bit eight, input bit two,
                            input bit par, input bit odd, input bit brk);
        logic [9:0] v;
        v = '0;
        v[0] = en; v[2] = eight; v[3] = two; v[4] = par; v[5] = odd; v[9] = brk;
        c_eight = eight; c_two = two; c_par = par; c_odd = odd;
        wr(2'd1, v);
    endtask

    // driver: records the expected frame, then writes the byte
    task automatic push_byte(input logic [7:0] b);
        frame_t f;
        f.data = b; f.nbits = c_eight ? 8 : 7; f.par_en = c_par;
        f.odd = c_odd; f.nstop = c_two ? 2 : 1;
        expq.push_back(f);
        wr(2'd2, {2'b00, b});
    endtask

    task automatic wait_drain();
        int t = 0;
        while ((expq.size() != 0 || tx_busy) && t < 40000) begin
            @(negedge clk); t++;
        end
        chk(expq.size() == 0, "R6 all queued frames sent", expq.size(), 0);
    endtask

    // monitor: decodes the line at mid-bit and compares against the queue
    initial begin : monitor
        frame_t     f;
        logic [7:0] got;
        logic [7:0] m;
        int         nb;
        forever begin
            @(negedge clk);
            if (mon_en && rst_n && txd === 1'b0) begin
                nb = bit_clks;
                repeat (nb/2) @(negedge clk);
                chk(txd == 1'b0, "R2 start bit low", txd, 0);
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unexpected frame", 1, 0);
                end else begin
                    f = expq.pop_front();
                    got = '0;
                    m = (f.nbits == 8) ? 8'hFF : 8'h7F;
                    for (int i = 0; i < f.nbits; i++) begin
                        repeat (nb) @(negedge clk);
                        got[i] = txd;
                    end
                    chk(got == (f.data & m), "R2 R3 data bits", got, f.data & m);
                    if (f.par_en) begin
                        repeat (nb) @(negedge clk);
                        chk(txd == ((^(f.data & m)) ^ f.odd), "R4 parity bit",
                            txd, (^(f.data & m)) ^ f.odd);
                    end
                    for (int s = 0; s < f.nstop; s++) begin
                        repeat (nb) @(negedge clk);
                        chk(txd == 1'b1, "R5 stop bit high", txd, 1);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle high", txd, 1);
        chk(fifo_index == 0, "R1 fifo empty", fifo_index, 0);
        chk(tx_busy == 1'b0, "R1 tx_busy low", tx_busy, 0);
        chk(div_busy == 1'b0, "R1 div_busy low", div_busy, 0);

        // R1 default divisor (32 clocks/bit), R2 8N1 frames
        set_line(1, 1, 0, 0, 0, 0);
        push_byte(8'h55);
        push_byte(8'hA3);
        push_byte(8'h01);
        wait_drain();

        // R10 busy covers the whole frame
        push_byte(8'h3C);
        chk(tx_busy == 1'b1, "R10 busy after push", tx_busy, 1);
        n = 0;
        while (tx_busy && n < 20 * bit_clks) begin @(negedge clk); n++; end
        chk(n >= 10 * bit_clks && n <= 11 * bit_clks + 2, "R10 busy falls after stop", n, 10 * bit_clks);
        chk(txd == 1'b1, "R10 idle line high", txd, 1);
        wait_drain();

        // R3 seven data bits, bit 7 dropped
        set_line(1, 0, 0, 0, 0, 0);
        push_byte(8'h80);
        push_byte(8'h7E);
        wait_drain();

        // R4 even then odd parity, 8 and 7 bits
        set_line(1, 1, 0, 1, 0, 0);
        push_byte(8'h03);
        push_byte(8'h07);
        wait_drain();
        set_line(1, 1, 0, 1, 1, 0);
        push_byte(8'h03);
        push_byte(8'h07);
        wait_drain();
        set_line(1, 0, 0, 1, 0, 0);
        push_byte(8'h81);
        wait_drain();

        // R5 two stop bits
        set_line(1, 1, 1, 0, 0, 0);
        push_byte(8'hF0);
        push_byte(8'h0F);
        wait_drain();

        // R8 divisor change to 3 (16 clocks per bit)
        wr(2'd0, 10'd3);
        chk(div_busy == 1'b1, "R8 div_busy raised", div_busy, 1);
        n = 0;
        while (div_busy && n < 4 * bit_clks) begin @(negedge clk); n++; end
        chk(n <= PRESCALE * 8 + 2, "R8 div_busy clears within one old bit", n, PRESCALE * 8);
        bit_clks = 4 * PRESCALE;
        set_line(1, 1, 0, 0, 0, 0);
        push_byte(8'hC5);
        push_byte(8'h2B);
        wait_drain();

        // R7 and R6: fill with transmission off, overflow dropped
        set_line(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) push_byte(8'(i * 17 + 3));
        chk(fifo_index == 5'd16, "R6 count reaches 16", fifo_index, 16);
        chk(fifo_index[4] == 1'b1, "R6 full bit 4 set", fifo_index[4], 1);
        wr(2'd2, 10'h0EE);
        chk(fifo_index == 5'd16, "R6 push while full dropped", fifo_index, 16);
        chk(tx_busy == 1'b1, "R10 busy with queued data", tx_busy, 1);
        bad = 0;
        repeat (4 * bit_clks) begin @(negedge clk); if (txd != 1'b1) bad++; end
        chk(bad == 0, "R7 no frame while disabled", bad, 0);
        chk(fifo_index == 5'd16, "R7 queue held while disabled", fifo_index, 16);
        set_line(1, 1, 0, 0, 0, 0);
        wait_drain();
        chk(fifo_index == 0, "R6 queue drained", fifo_index, 0);

        // R9 break from idle, then release
        mon_en = 1'b0;
        set_line(1, 1, 0, 0, 0, 1);
        n = 0;
        while (txd && n < 3 * bit_clks) begin @(negedge clk); n++; end
        chk(txd == 1'b0, "R9 break drives line low", txd, 0);
        bad = 0;
        repeat (3 * bit_clks) begin @(negedge clk); if (txd != 1'b0) bad++; end
        chk(bad == 0, "R9 break held low", bad, 0);
        set_line(1, 1, 0, 0, 0, 0);
        n = 0;
        while (!txd && n < 3 * bit_clks) begin @(negedge clk); n++; end
        chk(txd == 1'b1 && n <= bit_clks + 2, "R9 line released at bit boundary", n, bit_clks);
        mon_en = 1'b1;
        push_byte(8'h96);
        n = 0;
        while (txd && n < 3 * bit_clks) begin @(negedge clk); n++; end
        chk(n + 3 >= bit_clks, "R9 idle bit before next frame", n + 3, bit_clks);
        wait_drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule